// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer data path of a simple processor core. Each operation takes a first operand and a second operand that the barrel shifter upstream has already shifted, together with the carry that the shifter produced. From these it forms a result and a write-enable for the destination register. Four condition flags are held in a small register inside the block: negative, zero, carry and signed overflow. The core sets the set-flags input for operations that must update those flags. Operations that carry a value in from earlier ones read the stored carry flag. This lets software chain 32-bit additions and subtractions into wider ones.

The opcode selects one of sixteen operations. There are six arithmetic forms: add, add with carry, subtract, subtract with carry, and the two reversed subtractions. There are four bitwise forms and two pass-through forms. Four comparison forms change only the flags. Every subtraction runs on one shared adder as the addition of the inverted subtrahend. The carry flag after a subtraction therefore means that no borrow occurred.

Top module: `alu_nzcv_core`

## Requirements
- R1: Opcode 4 (add) gives `opa + opb`. Opcode 5 (add with carry) gives `opa + opb + C`. For both, the new C is the carry out of bit 31.
- R2: Opcode 2 (subtract) gives `opa - opb`. Opcode 6 (subtract with carry) gives `opa - opb - (1 - C)`. For both, the new C is 1 exactly when no borrow occurred.
- R3: Opcode 3 (reverse subtract) gives `opb - opa`. Opcode 7 (reverse subtract with carry) gives `opb - opa - (1 - C)`. The carry rule is the same as in R2.
- R4: The bitwise opcodes are 0 (`opa & opb`), 1 (`opa ^ opb`), 12 (`opa | opb`) and 14 (`opa & ~opb`).
- R5: Opcode 13 passes `opb` to the result unchanged. Opcode 15 passes `~opb`. The value of `opa` does not affect either result.
- R6: The comparison opcodes are 10 (flags of `opa - opb`), 11 (flags of `opa + opb`), 8 (flags of `opa & opb`) and 9 (flags of `opa ^ opb`). For these four opcodes `wr_en` is 0. For every other opcode `wr_en` is 1.
- R7: The flags load at a rising clock edge only when `set_flags` is 1 at that edge. When `set_flags` is 0 the flags keep their values. `result` and `wr_en` depend only on the present inputs and the stored C.
- R8: On an update, N takes bit 31 of the computed value. Z is 1 exactly when all 32 bits of the computed value are zero.
- R9: On an arithmetic or arithmetic-compare update, V is 1 exactly when the signed result does not fit in 32 bits.
- R10: On a bitwise, pass-through, test or test-equal update, C takes `shift_carry` and V keeps its previous value.
- R11: While `rst_n` is low, all four flags read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the shifter |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Load the flags at this edge |
| result | output | 32 | Computed value (combinational) |
| wr_en | output | 1 | Destination write enable (combinational) |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
`result` and `wr_en` are combinational, so they are valid in the same cycle as their stimulus. The flags are valid only after the next rising edge. The bench changes its inputs on the falling edge and reads `result` and `wr_en` one nanosecond later, well before the rising edge. It reads the four flags one nanosecond after that rising edge. A reference model in the bench, written with 64-bit signed and unsigned arithmetic, holds its own copy of the flags. Because of this, the chained operations that read the carry are checked against the carry that the bench expects.

// File: rtl/alu_nzcv_pkg.sv
`timescale 1ns/1ps
package alu_nzcv_pkg;

  typedef enum logic [3:0] {
    OP_AND     = 4'd0,
    OP_XOR     = 4'd1,
    OP_SUB     = 4'd2,
    OP_RSUB    = 4'd3,
    OP_ADD     = 4'd4,
    OP_ADDC    = 4'd5,
    OP_SUBC    = 4'd6,
    OP_RSUBC   = 4'd7,
    OP_TSTAND  = 4'd8,
    OP_TSTXOR  = 4'd9,
    OP_CMPSUB  = 4'd10,
    OP_CMPADD  = 4'd11,
    OP_OR      = 4'd12,
    OP_PASS    = 4'd13,
    OP_CLR     = 4'd14,
    OP_PASSN   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Operation classes
  function automatic logic op_is_compare(alu_op_e op);
    return (op == OP_TSTAND) || (op == OP_TSTXOR) ||
           (op == OP_CMPSUB) || (op == OP_CMPADD);
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_RSUB, OP_RSUBC,
      OP_CMPSUB, OP_CMPADD: return 1'b1;
      default:              return 1'b0;
    endcase
  endfunction

  // Signed overflow: carry into the top bit differs from carry out of it
  function automatic logic signed_ovf(logic x_top, logic y_top,
                                      logic s_top, logic c_out);
    return (x_top ^ y_top ^ s_top) ^ c_out;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic           c_flag,
  output logic [W-1:0]   sum,
  output logic           c_out,
  output logic           ovf
);
  localparam int TOP = W - 1;

  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         add_ci;
  logic [W:0]   wide;

  // Every subtract form becomes x + ~y + carry-in on the one adder
  always_comb begin
    add_x  = opa;
    add_y  = opb;
    add_ci = 1'b0;
    case (op)
      OP_ADDC:             add_ci = c_flag;
      OP_SUB, OP_CMPSUB: begin add_y = ~opb; add_ci = 1'b1;   end
      OP_SUBC:           begin add_y = ~opb; add_ci = c_flag; end
      OP_RSUB:           begin add_x = opb; add_y = ~opa; add_ci = 1'b1;   end
      OP_RSUBC:          begin add_x = opb; add_y = ~opa; add_ci = c_flag; end
      default: ;
    endcase
  end

  assign wide  = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
  assign sum   = wide[W-1:0];
  assign c_out = wide[W];
  assign ovf   = signed_ovf(add_x[TOP], add_y[TOP], sum[TOP], c_out);

endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_TSTAND: res = opa & opb;
      OP_XOR, OP_TSTXOR: res = opa ^ opb;
      OP_OR:             res = opa | opb;
      OP_CLR:            res = opa & ~opb;
      OP_PASS:           res = opb;
      OP_PASSN:          res = ~opb;
      default:           res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
  import alu_nzcv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  nzcv_t d,
  output nzcv_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= d;
  end
endmodule

// File: rtl/alu_nzcv_core.sv
`timescale 1ns/1ps
module alu_nzcv_core
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         shift_carry,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  localparam int TOP = W - 1;

  alu_op_e      op;
  logic [W-1:0] arith_sum;
  logic         arith_cout;
  logic         arith_ovf;
  logic [W-1:0] logic_res;
  logic         sel_arith;
  logic         sel_logic;
  nzcv_t        flags_q;
  nzcv_t        flags_d;

  assign op        = alu_op_e'(opcode);
  assign sel_arith = op_is_arith(op);
  assign sel_logic = !sel_arith;

  alu_addsub #(.W(W)) u_addsub (
    .op     (op),
    .opa    (opa),
    .opb    (opb),
    .c_flag (flags_q.c),
    .sum    (arith_sum),
    .c_out  (arith_cout),
    .ovf    (arith_ovf)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .op  (op),
    .opa (opa),
    .opb (opb),
    .res (logic_res)
  );

  assign result = sel_arith ? arith_sum : logic_res;
  assign wr_en  = !op_is_compare(op);

  always_comb begin
    flags_d.n = result[TOP];
    flags_d.z = (result == '0);
    flags_d.c = sel_arith ? arith_cout : shift_carry;
    flags_d.v = sel_arith ? arith_ovf  : flags_q.v;
  end

  alu_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (set_flags),
    .d     (flags_d),
    .q     (flags_q)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  // Flags without a set-flags request stay put
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags_q));

  // Zero and negative follow the value the update saw
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flag_z == ($past(result) == '0)));

  assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flag_n == $past(result[TOP])));

  // Bitwise-class updates take the shifter carry and keep V
  assert_shift_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && sel_logic) |=> (flag_c == $past(shift_carry)));

  assert_keep_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && sel_logic) |=> $stable(flag_v));

  // Adder overflow agrees with the sign-bit rule on the true operands
  assert_sign_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && (op == OP_ADD)) |=>
      (flag_v == (($past(opa[TOP]) == $past(opb[TOP])) &&
                  ($past(result[TOP]) != $past(opa[TOP])))));

endmodule

// File: tb/alu_nzcv_core_tb.sv
`timescale 1ns/1ps
module alu_nzcv_core_tb;
  import alu_nzcv_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        shift_carry = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic        set_flags = 1'b0;
  logic [31:0] result;
  logic        wr_en;
  logic        flag_n, flag_z, flag_c, flag_v;

  int n_checks = 0;
  int n_fails  = 0;
  logic [3:0] m_flags = 4'b0000; // model n,z,c,v

  always #4 clk = ~clk; // 125 MHz

  alu_nzcv_core u_dut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
    .shift_carry(shift_carry), .opcode(opcode), .set_flags(set_flags),
    .result(result), .wr_en(wr_en),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        shc;
    logic        s;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd10, 32'd4,          32'd4,          1'b0, 1'b1}, // compare equal
    '{4'd5,  32'd5,          32'd6,          1'b0, 1'b1}, // add with C=1
    '{4'd2,  32'd1,          32'd1,          1'b0, 1'b1}, // 1-1
    '{4'd6,  32'd10,         32'd3,          1'b0, 1'b1}, // sbc, C=1
    '{4'd10, 32'd0,          32'd1,          1'b0, 1'b1}, // borrow
    '{4'd6,  32'd10,         32'd3,          1'b0, 1'b1}, // sbc, C=0
    '{4'd3,  32'd3,          32'd10,         1'b0, 1'b1}, // reverse sub
    '{4'd7,  32'd3,          32'd10,         1'b1, 1'b1}, // reverse sbc
    '{4'd7,  32'd10,         32'd3,          1'b0, 1'b1}, // reverse sbc neg
    '{4'd4,  32'h7FFFFFFF,   32'd1,          1'b0, 1'b1}, // signed ovf
    '{4'd0,  32'hF0F0F0F0,   32'hFF00FF00,   1'b1, 1'b1}, // and, V kept
    '{4'd4,  32'hFFFFFFFF,   32'd1,          1'b0, 1'b1}, // wrap to zero
    '{4'd12, 32'h02040608,   32'h10305070,   1'b1, 1'b0}, // or, no S
    '{4'd1,  32'h0000FFFF,   32'h00FF00FF,   1'b0, 1'b1}, // xor
    '{4'd14, 32'b1111,       32'b0101,       1'b1, 1'b1}, // clear bits
    '{4'd13, 32'hDEADBEEF,   32'h80000004,   1'b1, 1'b1}, // pass
    '{4'd15, 32'h12345678,   32'h00000000,   1'b0, 1'b1}, // pass inverted
    '{4'd8,  32'h0000000F,   32'h000000F0,   1'b1, 1'b1}, // test and
    '{4'd9,  32'hA5A5A5A5,   32'hA5A5A5A5,   1'b0, 1'b1}, // test xor
    '{4'd11, 32'h80000000,   32'h80000000,   1'b0, 1'b1}  // compare add
  };

  function automatic logic fits32(longint v);
    return (v <= 64'sd2147483647) && (v >= -64'sd2147483648);
  endfunction

  // Independent model: wide integer arithmetic, returns {wr, nzcv, result}
  function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic shc, input logic [3:0] cur);
    longint ua, ub, sa, sb, u, s, brw, ci;
    logic [31:0] r;
    logic c, v, wr;
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    sa = longint'($signed(a)); sb = longint'($signed(b));
    c = shc; v = cur[0]; wr = 1'b1; r = '0;
    ci  = (op == 4'd5) ? longint'(cur[1]) : 0;
    brw = (op == 4'd6 || op == 4'd7) ? longint'(!cur[1]) : 0;
    case (op)
      4'd4, 4'd5, 4'd11: begin
        u = ua + ub + ci; s = sa + sb + ci;
        r = u[31:0]; c = u[32]; v = !fits32(s);
      end
      4'd2, 4'd6, 4'd10: begin
        u = ua - ub - brw; s = sa - sb - brw;
        r = u[31:0]; c = (u >= 0); v = !fits32(s);
      end
      4'd3, 4'd7: begin
        u = ub - ua - brw; s = sb - sa - brw;
        r = u[31:0]; c = (u >= 0); v = !fits32(s);
      end
      4'd0, 4'd8: r = a & b;
      4'd1, 4'd9: r = a ^ b;
      4'd12:      r = a | b;
      4'd14:      r = a & ~b;
      4'd13:      r = b;
      default:    r = ~b;
    endcase
    if (op >= 4'd8 && op <= 4'd11) wr = 1'b0;
    return {wr, r[31], (r == 32'd0), c, v, r};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd4, 4'd5:          return "R1";
      4'd2, 4'd6:          return "R2";
      4'd3, 4'd7:          return "R3";
      4'd0, 4'd1, 4'd12, 4'd14: return "R4";
      4'd13, 4'd15:        return "R5";
      default:             return "R6";
    endcase
  endfunction

  // Drive on falling edge, check result 1 ns later, flags 1 ns after rising edge
  task automatic run_op(input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic shc, input logic s);
    logic [36:0] e;
    @(negedge clk);
    opcode = op; opa = a; opb = b; shift_carry = shc; set_flags = s;
    e = model(op, a, b, shc, m_flags);
    #1;
    check(req_of(op), "result", result, e[31:0]);
    check("R6", "wr_en", {31'd0, wr_en}, {31'd0, e[36]});
    @(posedge clk);
    #1;
    if (s) m_flags = e[35:32];
    check(s ? "R8 R9 R10" : "R7", "flags nzcv",
          {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, m_flags});
  endtask

  logic [3:0] fl;
  assign fl = {flag_n, flag_z, flag_c, flag_v};

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #20;
    check("R11", "flags in reset", {28'd0, fl}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R8: 1 - 1 sets Z and C (no borrow)
    run_op(4'd2, 32'd1, 32'd1, 1'b0, 1'b1);
    check("R2", "1-1 flags", {28'd0, fl}, 32'b0110);
    // R6: compare 4 with 4 sets Z and C, no write
    run_op(4'd10, 32'd4, 32'd4, 1'b0, 1'b1);
    check("R6", "cmp 4,4 flags", {28'd0, fl}, 32'b0110);
    // R9: most positive plus one overflows
    run_op(4'd4, 32'h7FFFFFFF, 32'd1, 1'b0, 1'b1);
    check("R9", "ovf flags", {28'd0, fl}, 32'b1001);
    // R10: pass keeps V=1, takes shifter carry
    run_op(4'd13, 32'd0, 32'h80000004, 1'b1, 1'b1);
    check("R10", "pass flags", {28'd0, fl}, 32'b1011);
    // R5: pass inverted of zero, opa ignored
    @(negedge clk);
    opcode = 4'd15; opa = 32'hCAFEF00D; opb = 32'd0; set_flags = 1'b0;
    #1;
    check("R5", "inverted pass", result, 32'hFFFFFFFF);
    check("R5", "inverted pass wr", {31'd0, wr_en}, 32'd1);
    @(posedge clk); #1;
    check("R7", "no update", {28'd0, fl}, 32'b1011);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].shc, VECS[i].s);

    // R11: reset mid-run clears flags
    run_op(4'd2, 32'd0, 32'd1, 1'b0, 1'b1); // N set
    @(negedge clk); set_flags = 1'b0; rst_n = 1'b0;
    #1;
    check("R11", "flags after reset", {28'd0, fl}, 32'd0);
    m_flags = 4'b0000;
    @(negedge clk); rst_n = 1'b1;
    // R1: add with carry after reset uses C=0
    run_op(4'd5, 32'd100, 32'd23, 1'b0, 1'b1);
    check("R1", "adc after reset", result, 32'd123);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule